// File: doc/BRIEF.md
# Configuration Access Sequencer

This block turns one host request for a configuration read or write into a short series of accesses on a shared I/O target. The request names a device, function, byte offset, access size (1, 2 or 4 bytes) and whether the target sits behind a bridge. The sequencer works in three steps:

- It loads a configuration-address word into the target's address register.
- It makes a 32-bit access through the data window.
- It writes zero back to the address register, so the window returns to ordinary I/O use.

Sub-word writes are built as a read of the whole dword, a lane merge, and a write-back. Because a write has no completion indication, the sequencer waits a fixed, parameterised number of cycles before the restore. Requests that cannot be encoded are answered at once with a not-found status and make no bus access. Type-0 requests to the slot reserved for a downstream card are answered the same way.

The host side is a request/ready handshake with a one-cycle response pulse. The target side is a simple single-cycle bus. A select line picks either the address register (0) or the data window (1), and read data is registered by the target and returned in the cycle after the read.

Top module: `cfg_access_seq`

## Requirements
- R1: The address word carries the dword index (offset divided by 4) in bits 7:2, the function in bits 10:8 and the device in bits 15:11. Bits 31 and 30 are both 1 and bits 29:16 are 0.
- R2: Address-word bits 1:0 hold the cycle type: 0 when req_behind_bridge is 0, and 1 when it is 1.
- R3: A request with device above 31, function above 7 or offset above 255 gets rsp_not_found=1 in the cycle after acceptance, and the block drives no bus access for it.
- R4: A request with req_behind_bridge=0 to device RESERVED_SLOT (default 8) is refused as in R3. With req_behind_bridge=1 the same device is accepted.
- R5: A read makes exactly these accesses, one cycle apart except where noted: an address-register write, a window read, then two cycles later an address-register write of 0. The response follows one cycle after that write.
- R6: Read data in the response depends on the size code. For req_size 0 (byte) it is the dword shifted right by 8×(offset mod 4) and masked to 8 bits. For req_size 1 (half) it is masked to 16 bits in the same way, truncated to 32 bits, so a half at lane 3 returns only byte 3. For req_size 2 or 3 it is the whole dword, whatever the low offset bits are.
- R7: A write reads the window, then two cycles later writes the full dword to the window. For a byte or half write, the size-masked new value replaces the addressed lanes and all other bits are kept. A dword write replaces everything. Value bits above the size are ignored.
- R8: After the window write, exactly WAIT_CYCLES idle cycles pass before the address-register restore, which then follows as in R5.
- R9: req_ready is low from the cycle after acceptance through the response cycle, and each accepted request yields exactly one rsp_valid pulse.
- R10: During and right after reset, req_ready is 1 and bus_valid and rsp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_behind_bridge | input | 1 | Target lies behind a bridge (type-1 cycle) |
| req_dev | input | DEV_W | Device number |
| req_func | input | FUNC_W | Function number |
| req_offset | input | OFS_W | Byte offset in configuration space |
| req_size | input | 2 | 0 byte, 1 half, 2 or 3 dword |
| req_wdata | input | 32 | Write value, right-aligned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_not_found | output | 1 | Request refused, no bus access made |
| rsp_rdata | output | 32 | Read result (0 for writes) |
| bus_valid | output | 1 | Target access this cycle |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_sel_window | output | 1 | 0 = address register, 1 = data window |
| bus_wdata | output | 32 | Write data to target |
| bus_rdata | input | 32 | Registered read data, valid the cycle after a read |

## Verification
The bench builds the block with WAIT_CYCLES=4 instead of the default of tens of thousands. That keeps every write short, while the gap between window write and restore can still be checked to the exact cycle. Device, function and offset keep their default widths of 8, 4 and 10 bits. This puts devices 32 and up, functions 8 and up and offsets 256 and up within reach of the ports, so each rejection rule can be driven. RESERVED_SLOT stays at 8, which lets the bench compare type-0 and type-1 requests to the same slot.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'd0,
        SZ_HALF     = 2'd1,
        SZ_WORD     = 2'd2,
        SZ_WORD_ALT = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RD,
        ST_CAP,
        ST_WR,
        ST_WAIT,
        ST_RESTORE,
        ST_RESP
    } seq_state_e;

    typedef struct packed {
        logic        is_write;
        logic [1:0]  lane;
        size_e       size;
        logic [31:0] wdata;
    } cfg_op_t;

    function automatic logic is_subword(size_e sz);
        return (sz == SZ_BYTE) || (sz == SZ_HALF);
    endfunction

    function automatic logic [31:0] size_mask(size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] lane_extract(logic [31:0] dw, logic [1:0] lane, size_e sz);
        logic [4:0] sh;
        sh = {lane, 3'b000};
        if (is_subword(sz))
            return (dw >> sh) & size_mask(sz);
        return dw;
    endfunction

    function automatic logic [31:0] lane_merge(logic [31:0] dw, logic [31:0] val,
                                               logic [1:0] lane, size_e sz);
        logic [4:0]  sh;
        logic [31:0] m;
        sh = {lane, 3'b000};
        m  = size_mask(sz);
        if (is_subword(sz))
            return (dw & ~(m << sh)) | ((val & m) << sh);
        return val;
    endfunction

    function automatic logic [31:0] cfg_word_build(logic [4:0] dev, logic [2:0] func,
                                                   logic [5:0] dw_idx, logic type1);
        return {2'b11, 14'd0, dev, func, dw_idx, 1'b0, type1};
    endfunction

endpackage

// File: rtl/cfg_req_check.sv
module cfg_req_check
    import cfg_seq_pkg::*;
#(
    parameter int DEV_W         = 8,
    parameter int FUNC_W        = 4,
    parameter int OFS_W         = 10,
    parameter int RESERVED_SLOT = 8
) (
    input  logic [DEV_W-1:0]  dev,
    input  logic [FUNC_W-1:0] func,
    input  logic [OFS_W-1:2]  offset_dw,
    input  logic              behind_bridge,
    output logic              reject,
    output logic [31:0]       cfg_word
);

    logic dev_over;
    logic func_over;
    logic ofs_over;
    logic reserved_hit;

    generate
        if (DEV_W > 5) begin : g_dev_wide
            assign dev_over = |dev[DEV_W-1:5];
        end else begin : g_dev_narrow
            assign dev_over = 1'b0;
        end
        if (FUNC_W > 3) begin : g_func_wide
            assign func_over = |func[FUNC_W-1:3];
        end else begin : g_func_narrow
            assign func_over = 1'b0;
        end
        if (OFS_W > 8) begin : g_ofs_wide
            assign ofs_over = |offset_dw[OFS_W-1:8];
        end else begin : g_ofs_narrow
            assign ofs_over = 1'b0;
        end
    endgenerate

    assign reserved_hit = !behind_bridge && (dev == DEV_W'(RESERVED_SLOT));
    assign reject       = dev_over | func_over | ofs_over | reserved_hit;
    assign cfg_word     = cfg_word_build(5'(dev), 3'(func), 6'(offset_dw), behind_bridge);

endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int WAIT_CYCLES = 62500
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= '0;
        else if (run)  cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == CNT_W'(WAIT_CYCLES - 1));

    // R8
    wait_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (cnt == '0));

    // R8
    wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < CNT_W'(WAIT_CYCLES)));

endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
    import cfg_seq_pkg::*;
#(
    parameter int DEV_W         = 8,
    parameter int FUNC_W        = 4,
    parameter int OFS_W         = 10,
    parameter int WAIT_CYCLES   = 62500,
    parameter int RESERVED_SLOT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_behind_bridge,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_not_found,
    output logic [31:0]       rsp_rdata,
    output logic              bus_valid,
    output logic              bus_write,
    output logic              bus_sel_window,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata
);

    seq_state_e  state_q, state_d;
    cfg_op_t     op_q;
    logic [31:0] word_q;
    logic [31:0] dword_q;
    logic [31:0] rdata_q;
    logic        nf_q;
    logic        accept;
    logic        rej;
    logic [31:0] cfg_word_d;
    logic        wait_done;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    cfg_req_check #(
        .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFS_W(OFS_W), .RESERVED_SLOT(RESERVED_SLOT)
    ) u_check (
        .dev          (req_dev),
        .func         (req_func),
        .offset_dw    (req_offset[OFS_W-1:2]),
        .behind_bridge(req_behind_bridge),
        .reject       (rej),
        .cfg_word     (cfg_word_d)
    );

    cfg_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk (clk),
        .rst (rst),
        .load(state_q == ST_WR),
        .run (state_q == ST_WAIT),
        .done(wait_done)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (accept) state_d = rej ? ST_RESP : ST_ADDR;
            ST_ADDR:    state_d = ST_RD;
            ST_RD:      state_d = ST_CAP;
            ST_CAP:     state_d = op_q.is_write ? ST_WR : ST_RESTORE;
            ST_WR:      state_d = ST_WAIT;
            ST_WAIT:    if (wait_done) state_d = ST_RESTORE;
            ST_RESTORE: state_d = ST_RESP;
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            word_q  <= '0;
            dword_q <= '0;
            rdata_q <= '0;
            nf_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q    <= '{is_write: req_write, lane: req_offset[1:0],
                             size: size_e'(req_size), wdata: req_wdata};
                word_q  <= cfg_word_d;
                nf_q    <= rej;
                rdata_q <= '0;
            end
            if (state_q == ST_CAP) begin
                dword_q <= bus_rdata;
                if (!op_q.is_write)
                    rdata_q <= lane_extract(bus_rdata, op_q.lane, op_q.size);
            end
        end
    end

    always_comb begin
        bus_valid      = 1'b0;
        bus_write      = 1'b0;
        bus_sel_window = 1'b0;
        bus_wdata      = '0;
        case (state_q)
            ST_ADDR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = word_q;
            end
            ST_RD: begin
                bus_valid      = 1'b1;
                bus_sel_window = 1'b1;
            end
            ST_WR: begin
                bus_valid      = 1'b1;
                bus_write      = 1'b1;
                bus_sel_window = 1'b1;
                bus_wdata      = lane_merge(dword_q, op_q.wdata, op_q.lane, op_q.size);
            end
            ST_RESTORE: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
            end
            default: ;
        endcase
    end

    assign rsp_valid     = (state_q == ST_RESP);
    assign rsp_not_found = nf_q;
    assign rsp_rdata     = rdata_q;

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> !req_ready);

    // R1
    addr_word_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && !bus_sel_window) |->
        (bus_wdata == 32'd0 || (bus_wdata[31:30] == 2'b11 && bus_wdata[29:16] == 14'd0)));

    // R3
    reject_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && rej) |=> (rsp_valid && rsp_not_found && !bus_valid));

    // R5
    restore_first_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_not_found) |->
        $past(bus_valid && bus_write && !bus_sel_window && bus_wdata == 32'd0));

    // R7
    rmw_order_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_sel_window) |->
        $past(bus_valid && !bus_write && bus_sel_window, 2));

endmodule

// File: tb/cfg_access_seq_bench.sv
module cfg_access_seq_bench;

    localparam int W = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_behind_bridge = 1'b0;
    logic [7:0]  req_dev = '0;
    logic [3:0]  req_func = '0;
    logic [9:0]  req_offset = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_not_found;
    logic [31:0] rsp_rdata;
    logic        bus_valid;
    logic        bus_write;
    logic        bus_sel_window;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_cyc = 0;
    bit finished = 0;

    typedef struct {
        bit          wr;
        bit          sel;
        logic [31:0] d;
        int          gap;
        string       tag;
    } bop_t;
    bop_t exp_q[$];

    logic [31:0] tgt_addr = '0;
    logic [31:0] io_reg   = 32'h1357_9BDF;
    logic [31:0] mem [int];

    always #4 clk = ~clk;

    cfg_access_seq #(.WAIT_CYCLES(W)) u_cfg_access_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_behind_bridge(req_behind_bridge), .req_dev(req_dev), .req_func(req_func),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_not_found(rsp_not_found), .rsp_rdata(rsp_rdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_sel_window(bus_sel_window),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] mem_read(int k);
        if (mem.exists(k)) return mem[k];
        return 32'h9E37_0000 ^ (k * 32'h0001_0003) ^ 32'h00C3_5A96;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // target model: address register, config space and plain I/O register
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bus_valid && bus_write) begin
            if (!bus_sel_window) tgt_addr <= bus_wdata;
            else if (tgt_addr[31]) mem[int'(tgt_addr[15:0])] = bus_wdata;
            else io_reg <= bus_wdata;
        end
        if (bus_valid && !bus_write && bus_sel_window)
            bus_rdata <= tgt_addr[31] ? mem_read(int'(tgt_addr[15:0])) : io_reg;
    end

    // reference comparison of every bus cycle
    always @(negedge clk) begin
        if (!rst && bus_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3 unexpected bus access", bus_wdata, 32'd0);
            end else begin
                bop_t e;
                e = exp_q.pop_front();
                chk(bus_write == e.wr && bus_sel_window == e.sel, {e.tag, " op kind"},
                    {30'd0, bus_write, bus_sel_window}, {30'd0, e.wr, e.sel});
                if (e.wr) chk(bus_wdata == e.d, {e.tag, " write data"}, bus_wdata, e.d);
                chk(cyc - last_cyc == e.gap, {e.tag, " timing gap"}, cyc - last_cyc, e.gap);
            end
            last_cyc = cyc;
        end
    end

    task automatic push(bit wr, bit sel, logic [31:0] d, int gap, string tag);
        bop_t e;
        e.wr = wr; e.sel = sel; e.d = d; e.gap = gap; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic access(input bit wr, input bit bb, input int dev, input int func,
                          input int ofs, input int sz, input logic [31:0] wd, input string tag);
        bit          reject;
        logic [31:0] cfgw, old, m, expd, merged;
        logic [4:0]  sh;
        int          key;
        bit          got;
        reject = dev > 31 || func > 7 || ofs > 255 || (!bb && dev == 8);
        cfgw   = {2'b11, 14'd0, dev[4:0], func[2:0], ofs[7:2], 1'b0, bb};
        key    = int'(cfgw[15:0]);
        old    = mem_read(key);
        sh     = 5'(ofs[1:0] * 8);
        m      = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        expd   = (sz < 2) ? ((old >> sh) & m) : old;
        merged = (sz < 2) ? ((old & ~(m << sh)) | ((wd & m) << sh)) : wd;
        if (!reject) begin
            push(1, 0, cfgw, 1, "R1");
            push(0, 1, 32'd0, 1, "R5");
            if (wr) begin
                push(1, 1, merged, 2, "R7");
                push(1, 0, 32'd0, W + 1, "R8");
            end else begin
                push(1, 0, 32'd0, 2, "R5");
            end
        end
        @(negedge clk);
        req_write = wr; req_behind_bridge = bb; req_dev = 8'(dev); req_func = 4'(func);
        req_offset = 10'(ofs); req_size = 2'(sz); req_wdata = wd; req_valid = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        last_cyc = cyc - 1;
        got = 0;
        for (int i = 0; i < W + 20; i++) begin
            @(negedge clk);
            if (rsp_valid) begin got = 1; break; end
            chk(!req_ready, {tag, " R9 ready low while busy"}, req_ready, 0);
        end
        chk(got, {tag, " R9 response seen"}, got, 1);
        chk(cyc - last_cyc == 1, {tag, " R9 response timing"}, cyc - last_cyc, 1);
        chk(!req_ready, {tag, " R9 ready low in response"}, req_ready, 0);
        chk(rsp_not_found == reject, {tag, " status"}, rsp_not_found, reject);
        chk(exp_q.size() == 0, {tag, " all bus ops seen"}, exp_q.size(), 0);
        if (!reject) begin
            chk(rsp_rdata == (wr ? 32'd0 : expd), {tag, " read data"}, rsp_rdata, wr ? 32'd0 : expd);
            chk(tgt_addr == 32'd0, {tag, " R5 address restored"}, tgt_addr, 0);
            if (wr) chk(mem_read(key) == merged, {tag, " R7 stored dword"}, mem_read(key), merged);
        end
        exp_q.delete();
        @(negedge clk);
        chk(!rsp_valid, {tag, " R9 single pulse"}, rsp_valid, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (2) @(negedge clk);
        chk(req_ready && !bus_valid && !rsp_valid, "R10 during reset", {req_ready, bus_valid, rsp_valid}, 3'b100);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !bus_valid && !rsp_valid, "R10 after reset", {req_ready, bus_valid, rsp_valid}, 3'b100);

        // R1 / R5: dword read, type 0
        access(0, 0, 3, 1, 16'h10, 2, 0, "R1 dword read");
        // R2: type 1 access
        access(0, 1, 12, 5, 16'h3C, 3, 0, "R2 type1 read");
        // R6: byte lanes and half lanes
        for (int l = 0; l < 4; l++) access(0, 0, 5, 0, 32 + l, 0, 0, "R6 byte read");
        for (int l = 0; l < 4; l++) access(0, 0, 5, 0, 32 + l, 1, 0, "R6 half read");
        access(0, 0, 5, 0, 35, 2, 0, "R6 dword ignores low offset");
        // R7 / R8: writes
        for (int l = 0; l < 4; l++) access(1, 0, 6, 2, 64 + l, 0, 32'hFFFF_FF5A + l, "R7 byte write");
        access(1, 0, 6, 2, 72, 1, 32'hABCD_1234, "R7 half write lane0");
        access(1, 0, 6, 2, 75, 1, 32'h0000_BEEF, "R7 half write lane3");
        access(1, 1, 7, 3, 82, 2, 32'hCAFE_F00D, "R8 dword write");
        access(0, 1, 7, 3, 80, 2, 0, "R7 readback");
        // boundaries: max legal values accepted
        access(0, 0, 31, 7, 255, 0, 0, "R3 max fields accepted");
        // R3: out of range
        access(0, 0, 32, 0, 0, 2, 0, "R3 device 32");
        access(1, 0, 1, 8, 0, 2, 32'h1, "R3 function 8");
        access(0, 1, 1, 0, 256, 2, 0, "R3 offset 256");
        // R4: reserved slot
        access(1, 0, 8, 0, 4, 2, 32'h55, "R4 slot 8 type0 refused");
        access(0, 1, 8, 0, 4, 2, 0, "R4 slot 8 type1 accepted");
        // R5: plain I/O register never touched
        chk(io_reg == 32'h1357_9BDF, "R5 io register untouched", io_reg, 32'h1357_9BDF);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule